// File: doc/BRIEF.md
# Clocked Asynchronous SRAM Controller

This block sits between a synchronous host and an asynchronous byte-wide static memory. The host presents one word request at a time on a valid/ready handshake: a read or a write, an address and, for writes, a data byte. The controller turns each request into a sequence of active-low chip-select, write-enable and output-enable strobes. It holds each phase for enough clock cycles to meet the memory's setup, pulse-width, hold, access and release times, and then returns read data with a one-cycle valid flag.

Every memory timing figure is a parameter in nanoseconds. The controller converts each one to whole clock cycles by rounding up, using a clock-period parameter. An access passes through address setup, strobe, hold and turnaround phases. The hold phase is stretched when needed so that the minimum cycle time is met. The turnaround phase after a read lasts as long as the memory takes to release its outputs, so the controller never drives the data bus while the memory may still be driving it. The data bus is split into an output, an output-enable and an input, so the pad can be placed at the chip edge.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` and `rdata_valid` are low, and `req_ready` is high.
- R2: `req_ready` is high only while no access is in progress, and whenever it is high the chip select is high. With the default parameters and a 4 ns clock, a write keeps `req_ready` low for 7 cycles after acceptance and a read keeps it low for 9 cycles.
- R3: During a write, `mem_we_n` is low for exactly 4 consecutive cycles (the larger of 15 ns pulse and 12 ns data setup, rounded up). Chip select is low and output enable is high throughout that pulse.
- R4: Chip select is low with a stable address for 1 cycle before write enable falls. Address and chip select stay unchanged for 1 cycle after write enable rises. The address never changes while chip select is low.
- R5: For a write, the controller drives `mem_dq_out` from the first cycle of the access. The value stays constant through the write pulse and stays driven for 1 cycle after write enable rises. `mem_dq_oe` is never high during a read.
- R6: During a read, `mem_oe_n` is low for exactly 4 consecutive cycles (13 ns output-enable access and 20 ns address access, rounded up) while `mem_we_n` stays high.
- R7: Read data is sampled from `mem_dq_in` on the last output-enable cycle. `rdata_valid` is high for exactly one cycle, 6 cycles after the accepting edge, and `rdata` keeps its value until the next read completes.
- R8: `mem_dq_oe` is low whenever output enable is low and for at least 3 cycles (10 ns release) after output enable rises.
- R9: Each access holds chip select low for exactly 6 cycles, at least the 20 ns cycle time. Chip select returns high for at least one cycle between accesses.
- R10: A request raised and withdrawn while `req_ready` is low starts no access. Chip select stays high afterwards and memory content is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Last read data |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is updated |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_in | input | DATA_W | Data returned from the memory bus |

## Verification
The hardest case to reach from the ports is a read whose sample edge falls just after the memory's access time. Any error of one cycle in the strobe length would sample data that is not yet valid. The bench reaches this with a memory model that returns a poison byte until output enable has been low for 13 ns, measured in whole cycles. A shortened read strobe then returns the poison byte instead of the stored value.

Bus contention after a read is only visible when a write follows at once. The model keeps driving for its release time after output enable rises, so the bench issues a read and then a write directly after it. On every cycle it checks that the two drivers never overlap.

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 8,
  parameter int CLK_NS         = 4,
  parameter int ADDR_SU_NS     = 0,
  parameter int WE_PULSE_NS    = 15,
  parameter int DATA_SU_NS     = 12,
  parameter int DATA_HOLD_NS   = 2,
  parameter int ADDR_HOLD_NS   = 3,
  parameter int OE_ACCESS_NS   = 13,
  parameter int ADDR_ACCESS_NS = 20,
  parameter int CYCLE_NS       = 20,
  parameter int RELEASE_NS     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    return (ns <= 0) ? 1 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ASU_C  = cyc(ADDR_SU_NS);
  localparam int WSTB_C = max2(cyc(WE_PULSE_NS), cyc(DATA_SU_NS));
  localparam int RSTB_C = max2(cyc(OE_ACCESS_NS), cyc(ADDR_ACCESS_NS) - ASU_C);
  localparam int CYC_C  = cyc(CYCLE_NS);
  localparam int WHLD_C = max2(max2(cyc(DATA_HOLD_NS), cyc(ADDR_HOLD_NS)),
                               CYC_C - ASU_C - WSTB_C);
  localparam int RHLD_C = max2(1, CYC_C - ASU_C - RSTB_C);
  localparam int RTRN_C = cyc(RELEASE_NS);
  localparam int WTRN_C = 1;
  localparam int MAX_C  = max2(max2(max2(ASU_C, WSTB_C), max2(RSTB_C, WHLD_C)),
                               max2(RHLD_C, RTRN_C));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_ASU, S_STB, S_HLD, S_TRN} st_t;

  st_t              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic             accept, last, wr_nx, act_nx;

  assign req_ready  = (st_q == S_IDLE);
  assign accept     = req_ready && req_valid;
  assign last       = (cnt_q == '0);
  assign wr_nx      = req_ready ? req_write : wr_q;
  assign act_nx     = (st_d == S_ASU) || (st_d == S_STB) || (st_d == S_HLD);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        st_d  = S_ASU;
        cnt_d = CNT_W'(ASU_C - 1);
      end
      S_ASU: if (last) begin
        st_d  = S_STB;
        cnt_d = wr_q ? CNT_W'(WSTB_C - 1) : CNT_W'(RSTB_C - 1);
      end
      S_STB: if (last) begin
        st_d  = S_HLD;
        cnt_d = wr_q ? CNT_W'(WHLD_C - 1) : CNT_W'(RHLD_C - 1);
      end
      S_HLD: if (last) begin
        st_d  = S_TRN;
        cnt_d = wr_q ? CNT_W'(WTRN_C - 1) : CNT_W'(RTRN_C - 1);
      end
      S_TRN: if (last) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      mem_cs_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dq_oe   <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      mem_cs_n  <= !act_nx;
      mem_we_n  <= !((st_d == S_STB) && wr_nx);
      mem_oe_n  <= !((st_d == S_STB) && !wr_nx);
      mem_dq_oe <= act_nx && wr_nx;
      if (accept) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rdata_valid <= 1'b0;
      if (st_q == S_STB && last && !wr_q) begin
        rdata       <= mem_dq_in;
        rdata_valid <= 1'b1;
      end
    end
  end

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);
  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
  p_we_rise_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_cs_n);
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);
  p_no_drive_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || $rose(mem_oe_n)) |-> !mem_dq_oe);

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;
  localparam int CLK_NS = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rdata_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rdata, mem_addr, mem_dq_out, mem_dq_in;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_ctrl #(.ADDR_W(8), .DATA_W(8), .CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: poison until 13 ns of output enable, 10 ns release
  logic [7:0] mem_m [256];
  int oe_cnt = 0, rel = 0;
  logic model_drive;
  assign model_drive = !mem_oe_n || rel != 0;
  assign mem_dq_in = !model_drive ? 8'h00 :
                     ((oe_cnt + 1) * CLK_NS >= 13) ? mem_m[mem_addr] : 8'hEE;

  always @(posedge clk) begin
    oe_cnt <= !mem_oe_n ? oe_cnt + 1 : 0;
    if (!mem_oe_n) rel <= 3;
    else if (rel != 0) rel <= rel - 1;
  end

  // protocol monitor
  logic we_p = 1'b1, oe_p = 1'b1, cs_p = 1'b1;
  int we_w = 0, oe_w = 0, cs_w = 0;
  logic [7:0] a_fall, d_fall;
  bit d_ok;
  always @(negedge clk) if (rst_n && !done) begin
    if (mem_dq_oe && model_drive) chk(0, "R8 bus contention", 1, 0);
    if (!mem_cs_n) cs_w++;
    if (cs_p == 0 && mem_cs_n) begin chk(cs_w == 6, "R9 cs low width", cs_w, 6); cs_w = 0; end
    if (we_p && !mem_we_n) begin
      chk(cs_w == 2, "R4 setup before we", cs_w - 1, 1);
      chk(mem_dq_oe, "R5 data driven at we fall", mem_dq_oe, 1);
      a_fall = mem_addr; d_fall = mem_dq_out; d_ok = 1; we_w = 0;
    end
    if (!mem_we_n) begin
      we_w++;
      if (mem_dq_out != d_fall) d_ok = 0;
    end
    if (!we_p && mem_we_n) begin
      chk(we_w == 4, "R3 we pulse width", we_w, 4);
      chk(d_ok, "R5 data stable in pulse", d_ok, 1);
      chk(mem_dq_oe && mem_dq_out == d_fall, "R5 data hold", mem_dq_oe, 1);
      chk(!mem_cs_n && mem_addr == a_fall, "R4 addr hold", mem_addr, a_fall);
      mem_m[a_fall] = d_fall;
    end
    if (!mem_oe_n) begin
      oe_w++;
      if (!mem_we_n) chk(0, "R6 we low during read", 0, 1);
    end
    if (!oe_p && mem_oe_n) begin chk(oe_w == 4, "R6 oe width", oe_w, 4); oe_w = 0; end
    if (req_ready && !mem_cs_n) chk(0, "R2 ready while active", 1, 0);
    we_p = mem_we_n; oe_p = mem_oe_n; cs_p = mem_cs_n;
  end

  task automatic issue(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       output int busy, output int vpos, output int vcnt);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    busy = 0; vpos = 0; vcnt = 0;
    for (int n = 1; n <= 30; n++) begin
      if (n > 1) @(negedge clk);
      if (rdata_valid) begin vcnt++; vpos = n; end
      if (req_ready) break;
      busy++;
    end
  endtask

  task automatic t_reset;
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !rdata_valid, "R1 no drive no valid", {mem_dq_oe, rdata_valid}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [7:0] d);
    int b, p, c;
    issue(1, a, d, b, p, c);
    chk(b == 7, "R2 write busy cycles", b, 7);
    chk(c == 0, "R7 no valid on write", c, 0);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [7:0] e);
    int b, p, c;
    issue(0, a, 8'h00, b, p, c);
    chk(b == 9, "R2 read busy cycles", b, 9);
    chk(c == 1 && p == 6, "R7 valid pulse position", p, 6);
    chk(rdata == e, "R7 read data", rdata, e);
  endtask

  task automatic t_hold_rdata;
    int b, p, c;
    t_read(8'h12, 8'hA5);
    repeat (3) @(negedge clk);
    chk(rdata == 8'hA5, "R7 rdata held idle", rdata, 8'hA5);
    issue(1, 8'h13, 8'h77, b, p, c);
    chk(rdata == 8'hA5, "R7 rdata held across write", rdata, 8'hA5);
  endtask

  task automatic t_rd_then_wr;
    int b, p, c;
    issue(0, 8'h55, 8'h00, b, p, c);
    chk(rdata == 8'h3C, "R7 read before write", rdata, 8'h3C);
    issue(1, 8'h56, 8'hC3, b, p, c);
    chk(b == 7, "R8 write right after read", b, 7);
    t_read(8'h56, 8'hC3);
  endtask

  task automatic t_busy_ignore;
    int stray;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h40; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 8'h41; req_wdata = 8'h99;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    stray = 0;
    repeat (4) begin @(negedge clk); if (!mem_cs_n) stray++; end
    chk(stray == 0, "R10 no access from stray request", stray, 0);
    t_read(8'h41, 8'h00);
    t_read(8'h40, 8'h11);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write(8'h12, 8'hA5);
    t_read(8'h12, 8'hA5);
    t_write(8'h00, 8'h00);
    t_write(8'hFF, 8'hFF);
    t_write(8'h55, 8'h3C);
    t_read(8'hFF, 8'hFF);
    t_read(8'h00, 8'h00);
    t_read(8'h55, 8'h3C);
    t_read(8'h99, 8'h00);
    t_hold_rdata;
    t_rd_then_wr;
    t_busy_ignore;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule